// File: doc/BRIEF.md
# Out-of-Order Issue Window Scheduler

This block is a small pool of waiting instructions placed between the decode and execute stages of a dynamically scheduled core. Decode hands over instructions that have already been renamed. Each one carries a destination physical tag and two source physical tags, and each source carries a ready flag. An instruction is written into the lowest-numbered free slot. It waits there until both of its sources are ready, and then it may be issued, whatever its age relative to the other entries.

The execute side reports finished results by broadcasting a physical tag. Every waiting source that holds that tag is marked ready at the next clock edge. This includes a source that arrives from decode in the same cycle as the broadcast. Each cycle the scheduler presents at most one issuable entry to execute, and that entry leaves the window at the next edge. When more than one entry is ready, the lowest-numbered slot wins.

Decode must hold off while the full output is high. A mispredict flush discards every entry at once. During a flush cycle, the flush overrides any insertion and any issue in that cycle. An instruction that uses only one source passes the unused source in with its ready flag already set.

Top module: `iwin_sched`

## Requirements
- R1: After reset the window is empty: `iss_vld_o` and `ins_full_o` are both 0.
- R2: An instruction accepted with both ready flags set appears on `iss_vld_o`/`iss_dst_o` in the cycle after it is accepted.
- R3: A broadcast with `wake_vld_i` = 1 sets, at the next edge, the ready flag of every source in every valid entry whose tag equals `wake_tag_i`. A broadcast whose tag matches no source changes nothing.
- R4: A source inserted in the same cycle as a broadcast of its own tag is stored as ready.
- R5: Insertion uses the lowest-numbered free slot. When several entries are ready, the lowest-numbered one is issued.
- R6: An issued entry is freed at the edge that ends its issue cycle, so each instruction is issued exactly once.
- R7: `ins_full_o` is 1 exactly when all DEPTH slots are valid. An insertion offered while it is 1 is dropped.
- R8: While `flush_i` is 1, `iss_vld_o` is 0 and any insertion is dropped. After the flush edge the window is empty.
- R9: A younger instruction whose sources are ready issues ahead of an older instruction that is still waiting on a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| flush_i | input | 1 | Mispredict flush; empties the window |
| ins_vld_i | input | 1 | Decode offers an instruction |
| ins_dst_i | input | IWIN_TAG_W | Destination physical tag |
| ins_src0_i | input | IWIN_TAG_W | First source physical tag |
| ins_src0_rdy_i | input | 1 | First source already available |
| ins_src1_i | input | IWIN_TAG_W | Second source physical tag |
| ins_src1_rdy_i | input | 1 | Second source already available |
| wake_vld_i | input | 1 | A completion tag is broadcast |
| wake_tag_i | input | IWIN_TAG_W | Broadcast physical tag |
| ins_full_o | output | 1 | No free slot; decode must stall |
| iss_vld_o | output | 1 | An instruction is issued this cycle |
| iss_dst_o | output | IWIN_TAG_W | Destination tag of the issued instruction |
| iss_src0_o | output | IWIN_TAG_W | First source tag of the issued instruction |
| iss_src1_o | output | IWIN_TAG_W | Second source tag of the issued instruction |

## Verification
Two kinds of coincidence are provoked on purpose. In the first, an insertion falls in the same cycle as a broadcast of one of its source tags; it is judged correct only if that entry issues on the very next cycle. In the second, a flush is raised while a ready entry is being presented and an insertion is offered; both the issue and the insertion must vanish, and later broadcasts of the flushed entries' tags must bring nothing out. The bench also puts an insertion into a slot in the cycle after that slot issued, and checks that the newcomer overtakes older ready entries that sit in higher-numbered slots.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  // Physical tag width shared by every part of the window.
  parameter int unsigned IWIN_TAG_W = 6;

  typedef logic [IWIN_TAG_W-1:0] iwin_tag_t;

  typedef struct packed {
    iwin_tag_t tag;
    logic      rdy;
  } iwin_src_t;

  typedef struct packed {
    logic      vld;
    iwin_tag_t dst;
    iwin_src_t s0;
    iwin_src_t s1;
  } iwin_ent_t;
endpackage

// File: rtl/iwin_rst_sync.sv
module iwin_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/iwin_pick.sv
// Lowest-index one-hot selector.
module iwin_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  assign gnt_o = req_i & (~req_i + N'(1));
  assign any_o = |req_i;
endmodule

// File: rtl/iwin_entry.sv
module iwin_entry
  import iwin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush_i,
  input  logic      alloc_i,
  input  iwin_tag_t dst_i,
  input  iwin_tag_t src0_i,
  input  logic      src0_rdy_i,
  input  iwin_tag_t src1_i,
  input  logic      src1_rdy_i,
  input  logic      wake_vld_i,
  input  iwin_tag_t wake_tag_i,
  input  logic      issue_i,
  output logic      vld_o,
  output logic      ready_o,
  output iwin_tag_t dst_o,
  output iwin_tag_t src0_o,
  output iwin_tag_t src1_o
);
  iwin_ent_t ent_q, ent_d;
  logic      ent_en;

  always_comb begin
    ent_d = ent_q;
    if (flush_i) begin
      ent_d.vld = 1'b0;
    end else if (alloc_i) begin
      ent_d.vld    = 1'b1;
      ent_d.dst    = dst_i;
      ent_d.s0.tag = src0_i;
      ent_d.s1.tag = src1_i;
      ent_d.s0.rdy = src0_rdy_i | (wake_vld_i && (wake_tag_i == src0_i));
      ent_d.s1.rdy = src1_rdy_i | (wake_vld_i && (wake_tag_i == src1_i));
    end else if (ent_q.vld) begin
      if (issue_i) ent_d.vld = 1'b0;
      if (wake_vld_i && (wake_tag_i == ent_q.s0.tag)) ent_d.s0.rdy = 1'b1;
      if (wake_vld_i && (wake_tag_i == ent_q.s1.tag)) ent_d.s1.rdy = 1'b1;
    end
  end

  assign ent_en = flush_i | alloc_i | (ent_q.vld & (issue_i | wake_vld_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= '0;
    else if (ent_en) ent_q <= ent_d;
  end

  assign vld_o   = ent_q.vld;
  assign ready_o = ent_q.vld & ent_q.s0.rdy & ent_q.s1.rdy;
  assign dst_o   = ent_q.dst;
  assign src0_o  = ent_q.s0.tag;
  assign src1_o  = ent_q.s1.tag;
endmodule

// File: rtl/iwin_sched.sv
module iwin_sched
  import iwin_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic                  ins_vld_i,
  input  logic [IWIN_TAG_W-1:0] ins_dst_i,
  input  logic [IWIN_TAG_W-1:0] ins_src0_i,
  input  logic                  ins_src0_rdy_i,
  input  logic [IWIN_TAG_W-1:0] ins_src1_i,
  input  logic                  ins_src1_rdy_i,
  input  logic                  wake_vld_i,
  input  logic [IWIN_TAG_W-1:0] wake_tag_i,
  output logic                  ins_full_o,
  output logic                  iss_vld_o,
  output logic [IWIN_TAG_W-1:0] iss_dst_o,
  output logic [IWIN_TAG_W-1:0] iss_src0_o,
  output logic [IWIN_TAG_W-1:0] iss_src1_o
);
  logic             rst_sync_n;
  logic [DEPTH-1:0] vld_vec, rdy_vec;
  logic [DEPTH-1:0] free_gnt, rdy_gnt;
  logic [DEPTH-1:0] alloc_vec, issue_vec;
  logic             free_any, rdy_any, ins_take;
  iwin_tag_t        dst_arr  [DEPTH];
  iwin_tag_t        src0_arr [DEPTH];
  iwin_tag_t        src1_arr [DEPTH];

  iwin_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  iwin_pick #(.N(DEPTH)) u_free_pick (
    .req_i (~vld_vec),
    .gnt_o (free_gnt),
    .any_o (free_any)
  );

  iwin_pick #(.N(DEPTH)) u_rdy_pick (
    .req_i (rdy_vec),
    .gnt_o (rdy_gnt),
    .any_o (rdy_any)
  );

  assign ins_full_o = ~free_any;
  assign ins_take   = ins_vld_i & free_any & ~flush_i;
  assign alloc_vec  = free_gnt & {DEPTH{ins_take}};
  assign issue_vec  = rdy_gnt & {DEPTH{~flush_i}};
  assign iss_vld_o  = rdy_any & ~flush_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    iwin_entry u_ent (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .flush_i    (flush_i),
      .alloc_i    (alloc_vec[i]),
      .dst_i      (ins_dst_i),
      .src0_i     (ins_src0_i),
      .src0_rdy_i (ins_src0_rdy_i),
      .src1_i     (ins_src1_i),
      .src1_rdy_i (ins_src1_rdy_i),
      .wake_vld_i (wake_vld_i),
      .wake_tag_i (wake_tag_i),
      .issue_i    (issue_vec[i]),
      .vld_o      (vld_vec[i]),
      .ready_o    (rdy_vec[i]),
      .dst_o      (dst_arr[i]),
      .src0_o     (src0_arr[i]),
      .src1_o     (src1_arr[i])
    );
  end

  // One-hot AND-OR mux for the issued entry.
  always_comb begin
    iss_dst_o  = '0;
    iss_src0_o = '0;
    iss_src1_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rdy_gnt[i]) begin
        iss_dst_o  = iss_dst_o  | dst_arr[i];
        iss_src0_o = iss_src0_o | src0_arr[i];
        iss_src1_o = iss_src1_o | src1_arr[i];
      end
    end
  end
endmodule

// File: rtl/iwin_sched_chk.sv
module iwin_sched_chk
  import iwin_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush_i,
  input logic                  ins_vld_i,
  input logic                  ins_src0_rdy_i,
  input logic [IWIN_TAG_W-1:0] ins_src0_i,
  input logic                  ins_src1_rdy_i,
  input logic                  wake_vld_i,
  input logic [IWIN_TAG_W-1:0] wake_tag_i,
  input logic                  ins_full_o,
  input logic                  iss_vld_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  logic [CW-1:0] occ_q, occ_d;
  logic          accept;

  assign accept = ins_vld_i & ~ins_full_o & ~flush_i;

  always_comb begin
    occ_d = occ_q;
    if (flush_i) occ_d = '0;
    else         occ_d = occ_q + CW'(accept) - CW'(iss_vld_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  assert_full_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_full_o == (occ_q == CW'(DEPTH)));

  assert_issue_has_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld_o |-> (occ_q != '0));

  assert_flush_blocks_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !iss_vld_o);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!ins_full_o && (flush_i || !iss_vld_o)));

  assert_ready_insert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ins_src0_rdy_i && ins_src1_rdy_i) |=> (iss_vld_o || flush_i));

  assert_wake_on_insert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ins_src0_rdy_i && ins_src1_rdy_i && wake_vld_i && (wake_tag_i == ins_src0_i))
      |=> (iss_vld_o || flush_i));
endmodule

bind iwin_sched iwin_sched_chk #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .flush_i        (flush_i),
  .ins_vld_i      (ins_vld_i),
  .ins_src0_rdy_i (ins_src0_rdy_i),
  .ins_src0_i     (ins_src0_i),
  .ins_src1_rdy_i (ins_src1_rdy_i),
  .wake_vld_i     (wake_vld_i),
  .wake_tag_i     (wake_tag_i),
  .ins_full_o     (ins_full_o),
  .iss_vld_o      (iss_vld_o)
);

// File: tb/tb_iwin_sched.sv
module tb_iwin_sched;
  import iwin_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int NTAG       = 1 << IWIN_TAG_W;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            flush_i, ins_vld_i, ins_src0_rdy_i, ins_src1_rdy_i, wake_vld_i;
  logic [IWIN_TAG_W-1:0] ins_dst_i, ins_src0_i, ins_src1_i, wake_tag_i;
  logic            ins_full_o, iss_vld_o;
  logic [IWIN_TAG_W-1:0] iss_dst_o, iss_src0_o, iss_src1_o;

  int checks = 0;
  int errors = 0;
  int log_q [64];
  int log_n = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iwin_sched #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .ins_vld_i(ins_vld_i), .ins_dst_i(ins_dst_i),
    .ins_src0_i(ins_src0_i), .ins_src0_rdy_i(ins_src0_rdy_i),
    .ins_src1_i(ins_src1_i), .ins_src1_rdy_i(ins_src1_rdy_i),
    .wake_vld_i(wake_vld_i), .wake_tag_i(wake_tag_i),
    .ins_full_o(ins_full_o), .iss_vld_o(iss_vld_o),
    .iss_dst_o(iss_dst_o), .iss_src0_o(iss_src0_o), .iss_src1_o(iss_src1_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    flush_i = 0; ins_vld_i = 0; wake_vld_i = 0;
    ins_dst_i = '0; ins_src0_i = '0; ins_src1_i = '0;
    ins_src0_rdy_i = 0; ins_src1_rdy_i = 0; wake_tag_i = '0;
  endtask

  task automatic put(input int dst, input int s0, input bit r0, input int s1, input bit r1);
    ins_vld_i = 1;
    ins_dst_i = IWIN_TAG_W'(dst);
    ins_src0_i = IWIN_TAG_W'(s0); ins_src0_rdy_i = r0;
    ins_src1_i = IWIN_TAG_W'(s1); ins_src1_rdy_i = r1;
  endtask

  task automatic wake(input int t);
    wake_vld_i = 1; wake_tag_i = IWIN_TAG_W'(t);
  endtask

  // One clock: log what is issued, pass the edge, settle, clear inputs.
  task automatic cyc();
    if (iss_vld_o && log_n < 64) begin
      log_q[log_n] = int'(iss_dst_o);
      log_n++;
    end
    @(posedge clk);
    #1;
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 iss_vld in reset", int'(iss_vld_o), 0);
    rst_n = 1;
    repeat (3) cyc();
    chk("R1 iss_vld after reset", int'(iss_vld_o), 0);
    chk("R1 full after reset", int'(ins_full_o), 0);

    // R2 / R6: ready insert issues next cycle, exactly once
    put(5, 1, 1, 2, 1);
    chk("R2 no issue before insert edge", int'(iss_vld_o), 0);
    cyc();
    chk("R2 issue valid", int'(iss_vld_o), 1);
    chk("R2 issue dst", int'(iss_dst_o), 5);
    chk("R2 issue src0", int'(iss_src0_o), 1);
    chk("R2 issue src1", int'(iss_src1_o), 2);
    cyc();
    chk("R6 freed after issue", int'(iss_vld_o), 0);
    cyc();
    chk("R6 issued once", log_n, 1);

    // R7 / R5: fill, reject while full, then order of issue with refill
    log_n = 0;
    for (int k = 1; k <= DEPTH; k++) begin
      put(k, 9, 0, 0, 1);
      cyc();
      chk("R7 full vs occupancy", int'(ins_full_o), (k == DEPTH) ? 1 : 0);
    end
    put(7, 0, 1, 0, 1);
    cyc();
    chk("R7 insert while full dropped", int'(iss_vld_o), 0);
    chk("R7 still full", int'(ins_full_o), 1);
    wake(9);
    cyc();
    chk("R3 broadcast wakes all", int'(iss_vld_o), 1);
    cyc();
    chk("R5 slot freed by issue", int'(ins_full_o), 0);
    put(8, 0, 1, 0, 1);
    cyc();
    repeat (4) cyc();
    chk("R5 issue count", log_n, 5);
    chk("R5 order 0", log_q[0], 1);
    chk("R5 order 1", log_q[1], 2);
    chk("R5 refill lowest slot wins", log_q[2], 8);
    chk("R5 order 3", log_q[3], 3);
    chk("R5 order 4", log_q[4], 4);

    // R9 / R3: younger ready overtakes older waiter
    log_n = 0;
    put(1, 10, 0, 0, 1);
    cyc();
    put(2, 0, 1, 0, 1);
    cyc();
    chk("R9 younger issues first", int'(iss_dst_o), 2);
    cyc();
    chk("R9 older still waiting", int'(iss_vld_o), 0);
    wake(10);
    cyc();
    chk("R3 woken entry issues", int'(iss_vld_o), 1);
    chk("R3 woken entry dst", int'(iss_dst_o), 1);
    cyc();

    // R4: broadcast in insert cycle
    put(3, 0, 1, 11, 0);
    wake(11);
    cyc();
    chk("R4 same-cycle wake issue", int'(iss_vld_o), 1);
    chk("R4 same-cycle wake dst", int'(iss_dst_o), 3);
    cyc();
    chk("R4 drained", int'(iss_vld_o), 0);

    // R8: flush against issue and insert
    log_n = 0;
    for (int k = 1; k <= 2; k++) begin
      put(k, 20, 0, 0, 1);
      cyc();
    end
    put(5, 0, 1, 0, 1);
    cyc();
    chk("R8 ready entry before flush", int'(iss_vld_o), 1);
    flush_i = 1;
    put(9, 0, 1, 0, 1);
    #1;
    chk("R8 issue blocked in flush cycle", int'(iss_vld_o), 0);
    cyc();
    chk("R8 empty after flush", int'(iss_vld_o), 0);
    chk("R8 not full after flush", int'(ins_full_o), 0);
    wake(20);
    cyc();
    repeat (2) cyc();
    chk("R8 nothing survives flush", log_n, 0);

    // R3 sweep over all tags: non-matching broadcast ignored, both sources needed
    for (int t = 0; t < NTAG; t++) begin
      put(t, t, 0, (t + 1) % NTAG, 0);
      cyc();
      wake((t + 2) % NTAG);
      cyc();
      chk("R3 non-matching tag ignored", int'(iss_vld_o), 0);
      wake(t);
      cyc();
      chk("R3 one source still waiting", int'(iss_vld_o), 0);
      wake((t + 1) % NTAG);
      cyc();
      chk("R3 both sources woken", int'(iss_vld_o), 1);
      chk("R3 sweep dst", int'(iss_dst_o), t);
      cyc();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule